// File: doc/BRIEF.md
# Phase-Detector Lock Monitor

This block watches the up and down pulses of a phase-frequency detector and raises an active-high lock flag once the loop has settled. A fast sample clock counts how many of its periods carry an active up or down pulse. The count restarts on every reference-cycle strobe, so each detector cycle yields one phase-error figure in sample clocks.

At each strobe that figure is judged against two separate thresholds. A small error lets the monitor declare lock. Only a much larger error takes lock away again. This hysteresis stops the flag from chattering on a loop that has settled but is noisy. A mode input chooses whether three or five consecutive small-error cycles are needed before lock is declared. The output is meant to drive status logic or a lock indicator pin.

Top module: `pll_lock_monitor`

## Requirements
- R1: While rst_n is low, lock_o is low and the run of good cycles is cleared. After reset is released, a full run of good cycles is needed again before lock_o rises.
- R2: The phase error of a detector cycle is the number of sample-clock periods in which pfd_up or pfd_dn (or both) is high. The count covers the periods from the previous strobe period up to the period before the current strobe. A period with both pulses high counts once.
- R3: With long_mode = 0, lock_o rises after the third consecutive strobe whose error is below LOCK_THR (default 4 sample clocks).
- R4: With long_mode = 1, lock_o rises after the fifth consecutive strobe whose error is below LOCK_THR.
- R5: While unlocked, a strobe whose error is at or above LOCK_THR resets the run of good cycles to zero.
- R6: While locked, one strobe whose error is above UNLOCK_THR (default 6 sample clocks) clears lock_o.
- R7: While locked, errors from LOCK_THR up to and including UNLOCK_THR leave lock_o high.
- R8: lock_o changes only in the sample-clock period that follows a strobe period. It is never updated between strobes.
- R9: The error count saturates at its maximum (255 with CNT_W = 8). A very long pulse therefore counts as a large error and never wraps around to a small value.
- R10: The run length required is taken from long_mode as sampled at each strobe. A run that is already at or past the newly required length locks on the next good cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfd_up | input | 1 | Detector up pulse |
| pfd_dn | input | 1 | Detector down pulse |
| ref_strobe | input | 1 | One-period strobe that closes each detector cycle |
| long_mode | input | 1 | 0: three good cycles to lock, 1: five |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The hardest case to reach from the ports is saturation of the error counter. A window must hold more than 255 active sample periods, and its wrapped value must land in the good band, so that a counter that wraps would wrongly extend a run or keep a lock. The stimulus drives windows of exactly 258 active periods, once part-way through a run and once while locked. It also switches long_mode in the middle of a run to reach the case where the run is already past the newly required length.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // error strictly below the lock threshold counts as a good cycle
  function automatic logic err_small(input int unsigned err, input int unsigned thr);
    return err < thr;
  endfunction

  // error strictly above the unlock threshold drops an existing lock
  function automatic logic err_large(input int unsigned err, input int unsigned thr);
    return err > thr;
  endfunction

  // number of consecutive good cycles demanded by the mode bit
  function automatic int unsigned runs_needed(input logic long_sel,
                                              input int unsigned short_n,
                                              input int unsigned long_n);
    return long_sel ? long_n : short_n;
  endfunction

endpackage

// File: rtl/phase_err_meter.sv
module phase_err_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfd_up,
  input  logic             pfd_dn,
  input  logic             ref_strobe,
  output logic [CNT_W-1:0] win_err
);
  localparam logic [CNT_W-1:0] ERR_MAX = '1;

  logic             pulse_on;
  logic             err_sat;
  logic [CNT_W-1:0] err_q;

  assign pulse_on = pfd_up | pfd_dn;
  assign err_sat  = (err_q == ERR_MAX);
  assign win_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (ref_strobe) begin
      err_q <= CNT_W'(pulse_on);
    end else if (pulse_on && !err_sat) begin
      err_q <= err_q + 1'b1;
    end
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_strobe && err_sat) |=> (win_err == ERR_MAX));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_strobe && !pfd_up && !pfd_dn) |=> $stable(win_err));

  // R2
  window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_strobe |=> (win_err <= CNT_W'(1)));

endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import lockdet_pkg::*;
#(
  parameter int          CNT_W      = 8,
  parameter int unsigned LOCK_THR   = 4,
  parameter int unsigned UNLOCK_THR = 6,
  parameter int unsigned SHORT_RUN  = 3,
  parameter int unsigned LONG_RUN   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_strobe,
  input  logic             long_mode,
  input  logic [CNT_W-1:0] win_err,
  output logic             lock_o
);
  localparam int unsigned MAX_RUN = (SHORT_RUN > LONG_RUN) ? SHORT_RUN : LONG_RUN;
  localparam int          RUN_W   = $clog2(MAX_RUN + 1);

  logic             win_small;
  logic             win_large;
  logic             run_full;
  int unsigned      need;
  logic             lock_q;
  logic [RUN_W-1:0] run_q;

  assign win_small = err_small(32'(win_err), LOCK_THR);
  assign win_large = err_large(32'(win_err), UNLOCK_THR);
  assign need      = runs_needed(long_mode, SHORT_RUN, LONG_RUN);
  assign run_full  = (32'(run_q) + 32'd1) >= need;
  assign lock_o    = lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (ref_strobe) begin
      if (lock_q) begin
        if (win_large) begin
          lock_q <= 1'b0;
          run_q  <= '0;
        end
      end else if (win_small) begin
        if (run_full) begin
          lock_q <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!lock_q && run_q == '0));

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(ref_strobe && win_small));

  // R6
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(ref_strobe && win_large));

  // R7
  hold_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && ref_strobe && !win_large) |=> lock_q);

  // R5
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && ref_strobe && !win_small) |=> (run_q == '0 && !lock_q));

  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_q) < MAX_RUN);

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int          CNT_W      = 8,
  parameter int unsigned LOCK_THR   = 4,
  parameter int unsigned UNLOCK_THR = 6,
  parameter int unsigned SHORT_RUN  = 3,
  parameter int unsigned LONG_RUN   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pfd_up,
  input  logic pfd_dn,
  input  logic ref_strobe,
  input  logic long_mode,
  output logic lock_o
);
  logic [CNT_W-1:0] win_err;

  phase_err_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .pfd_up     (pfd_up),
    .pfd_dn     (pfd_dn),
    .ref_strobe (ref_strobe),
    .win_err    (win_err)
  );

  lock_qualifier #(
    .CNT_W      (CNT_W),
    .LOCK_THR   (LOCK_THR),
    .UNLOCK_THR (UNLOCK_THR),
    .SHORT_RUN  (SHORT_RUN),
    .LONG_RUN   (LONG_RUN)
  ) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_strobe (ref_strobe),
    .long_mode  (long_mode),
    .win_err    (win_err),
    .lock_o     (lock_o)
  );

  // R8
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ref_strobe) |-> $stable(lock_o));

endmodule

// File: tb/pll_lock_monitor_test.sv
module pll_lock_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfd_up = 1'b0;
  logic pfd_dn = 1'b0;
  logic ref_strobe = 1'b0;
  logic long_mode = 1'b0;
  logic lock_o;

  int checks = 0;
  int fails = 0;
  bit exp_lock = 1'b0;
  int exp_run = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_lock_monitor uut (
    .clk(clk), .rst_n(rst_n), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .ref_strobe(ref_strobe), .long_mode(long_mode), .lock_o(lock_o)
  );

  function automatic int sat_err(input int active);
    return (active > 255) ? 255 : active;
  endfunction

  function automatic int need_of(input bit m);
    return m ? 5 : 3;
  endfunction

  task automatic chk(input logic got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: lock_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_step(input int err, input bit m);
    if (exp_lock) begin
      if (err > 6) begin exp_lock = 1'b0; exp_run = 0; end
    end else if (err < 4) begin
      if (exp_run + 1 >= need_of(m)) begin exp_lock = 1'b1; exp_run = 0; end
      else exp_run++;
    end else begin
      exp_run = 0;
    end
  endtask

  // pattern: 0 random up/dn/both, 3 both high every active period
  task automatic window(input int active, input bit m, input int pattern, input string req);
    long_mode = m;
    for (int i = 0; i < active; i++) begin
      @(negedge clk);
      chk(lock_o, exp_lock, "R8");
      if (pattern == 3) begin
        pfd_up = 1'b1; pfd_dn = 1'b1;
      end else begin
        case ($urandom % 3)
          0: begin pfd_up = 1'b1; pfd_dn = 1'b0; end
          1: begin pfd_up = 1'b0; pfd_dn = 1'b1; end
          default: begin pfd_up = 1'b1; pfd_dn = 1'b1; end
        endcase
      end
    end
    for (int i = 0; i < 1 + int'($urandom % 3); i++) begin
      @(negedge clk);
      pfd_up = 1'b0; pfd_dn = 1'b0;
    end
    @(negedge clk);
    chk(lock_o, exp_lock, "R8");
    pfd_up = 1'b0; pfd_dn = 1'b0;
    ref_strobe = 1'b1;
    @(negedge clk);
    ref_strobe = 1'b0;
    model_step(sat_err(active), m);
    chk(lock_o, exp_lock, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(lock_o, 1'b0, "R1");
    rst_n = 1'b1;
    exp_lock = 1'b0;
    exp_run = 0;
    @(negedge clk);
    chk(lock_o, 1'b0, "R1");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R2 and R3: both pulses high count once, three good cycles lock
    window(3, 1'b0, 3, "R2");
    window(3, 1'b0, 3, "R2");
    window(3, 1'b0, 3, "R3");
    chk(lock_o, 1'b1, "R3");

    // R7: middle errors keep lock; R6: large error drops it
    window(4, 1'b0, 0, "R7");
    window(6, 1'b0, 0, "R7");
    window(5, 1'b0, 0, "R7");
    chk(lock_o, 1'b1, "R7");
    window(7, 1'b0, 0, "R6");
    chk(lock_o, 1'b0, "R6");

    // R4: five good cycles needed in long mode
    for (int k = 0; k < 5; k++) window(k % 4, 1'b1, 0, "R4");
    chk(lock_o, 1'b1, "R4");
    window(20, 1'b1, 0, "R6");

    // R5: a middle error restarts the run while unlocked
    window(2, 1'b0, 0, "R5");
    window(1, 1'b0, 0, "R5");
    window(4, 1'b0, 0, "R5");
    window(0, 1'b0, 0, "R5");
    window(3, 1'b0, 0, "R5");
    chk(lock_o, 1'b0, "R5");
    window(2, 1'b0, 0, "R5");
    chk(lock_o, 1'b1, "R5");

    // R9: a 258-period window must not wrap to a small error
    window(258, 1'b0, 0, "R9");
    chk(lock_o, 1'b0, "R9");
    window(1, 1'b0, 0, "R9");
    window(1, 1'b0, 0, "R9");
    window(258, 1'b0, 0, "R9");
    window(1, 1'b0, 0, "R9");
    chk(lock_o, 1'b0, "R9");

    // R10: run of four in long mode locks on next good cycle in short mode
    window(9, 1'b1, 0, "R10");
    for (int k = 0; k < 4; k++) window(1, 1'b1, 0, "R10");
    chk(lock_o, 1'b0, "R10");
    window(2, 1'b0, 0, "R10");
    chk(lock_o, 1'b1, "R10");
    window(30, 1'b0, 0, "R6");

    // R1: reset in mid-run clears the run
    window(1, 1'b0, 0, "R1");
    window(1, 1'b0, 0, "R1");
    do_reset();
    window(1, 1'b0, 0, "R1");
    chk(lock_o, 1'b0, "R1");

    // random windows across good, middle and large bands
    for (int k = 0; k < 120; k++) begin
      int band;
      int act;
      bit m;
      band = int'($urandom % 10);
      if (band < 6) act = int'($urandom % 4);
      else if (band < 8) act = 4 + int'($urandom % 3);
      else act = 7 + int'($urandom % 14);
      m = (($urandom % 8) == 0) ? ~long_mode : long_mode;
      window(act, m, 0, "R3");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule